// File: doc/BRIEF.md
# NRZI Serial Symbol Receiver

This block sits behind a clock-recovery stage. It takes the recovered serial bit stream, in NRZI form, together with the recovered bit clock. It picks either the line input or a local loopback input, decodes NRZI to NRZ and shifts the bits into a five-bit shifter. It also makes a symbol clock by dividing the bit clock by five. On every falling edge of that symbol clock, the last five received bits are presented as one unframed parallel symbol. No boundary search is performed: each group simply follows the phase of the divider.

A signal-detect input comes from the optical or copper receiver. It is registered on the local reference clock and sent back out unchanged. A copy of it, brought into the bit-clock domain, qualifies the line data. When the line is selected and signal detect is low, the serial data is gated off and the parallel output is held at zero. While loopback is selected, signal detect has no effect. Everything in the bit-clock domain runs from the single recovered bit clock. The symbol clock is a registered output that downstream logic uses as its strobe.

Top module: `nrzi_symbol_rx`

## Requirements
- R1: With `loop_n` high the decoder takes `line_sin`; with `loop_n` low it takes `loop_sin`; the unselected serial input has no effect on `sym_data`.
- R2: While `loop_n` is low, `sd_in` has no effect on `sym_data`; symbols decode normally with signal detect low or toggling.
- R3: With `loop_n` high and signal detect (after synchronisation) low, `sym_data` is all zeros within a bounded number of bit clocks and stays zero while the condition lasts.
- R4: The NRZ bit is 1 when the sampled serial bit differs from the bit sampled one bit clock earlier, else 0; the stored previous bit is 0 after reset.
- R5: `sym_clk` repeats every 5 bit clocks, high for 2 and low for 3; it is high during the first two bit clocks after reset is released.
- R6: `sym_data` changes only on the bit-clock edge at which `sym_clk` falls (or when forced to zero by R3 or R9).
- R7: The symbol loaded when `sym_clk` falls holds the NRZ bits sampled on that edge and on the four edges before it; the earliest of the five is in bit 4, and the one sampled on the falling edge itself is in bit 0.
- R8: `sd_out` equals `sd_in` as sampled on the previous rising edge of `ref_clk`, with the same polarity.
- R9: Synchronous active-low `rst_n`, sampled on `bit_clk`, clears the divider, the shifter, the previous-bit state and `sym_data`; during reset `sym_data` is 0 and `sym_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered serial bit clock |
| ref_clk | input | 1 | Local reference clock for signal-detect sampling |
| rst_n | input | 1 | Synchronous active-low reset (bit clock domain) |
| loop_n | input | 1 | Active-low loopback select |
| line_sin | input | 1 | Line serial NRZI data |
| loop_sin | input | 1 | Loopback serial NRZI data |
| sd_in | input | 1 | Asynchronous signal-detect input, high means signal present |
| sym_clk | output | 1 | Divide-by-five symbol clock, 2 high / 3 low |
| sym_data | output | 5 | Parallel unframed symbol, earliest bit in bit 4 |
| sd_out | output | 1 | Signal detect registered on ref_clk |

## Verification
All 32 symbol values are swept through both the line and loopback paths, with noise on the unselected input. Wrong mux polarity or a leak from the unselected input therefore garbles the decoded words. Streams start right after reset with a first bit of 1. A previous-bit state that does not reset to 0, or a decoder using XNOR, gives inverted bits. A bit order reversed within the group, or a load on the wrong edge of the divider, shows up as a wrong value or a change outside the falling edge. Signal detect is toggled in loopback, where a design that gates there loses symbols. It is dropped in line mode, where a design that skips the gating keeps passing data instead of holding zeros.

// File: rtl/nsr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the NRZI serial symbol receiver.
// Assumes a five-bit symbol and a 2-bit-high symbol clock by default.
package nsr_pkg;
    localparam int unsigned SYM_BITS_DEF  = 5;
    localparam int unsigned HIGH_BITS_DEF = 2;
    localparam int unsigned SYNC_DEF      = 2;
endpackage

// File: rtl/nsr_line_select.sv
`timescale 1ns/1ps
// Module: source select and signal-detect qualification.
// Registers sd_in on ref_clk, carries it into the bit_clk domain through
// SYNC_STAGES flops, and picks line or loopback data. Line data is forced
// to 0 when the line is selected and signal detect is low.
// Assumes: the signal-detect flops are not reset (they only track sd_in).
module nsr_line_select #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic bit_clk,
    input  logic ref_clk,
    input  logic loop_n,
    input  logic line_sin,
    input  logic loop_sin,
    input  logic sd_in,
    output logic sd_out,
    output logic sd_sync,
    output logic gate,
    output logic ser_bit
);
    logic                   sd_ref_q;
    logic [SYNC_STAGES-1:0] sync_q;

    // Sample signal detect on the local reference clock.
    always_ff @(posedge ref_clk) begin
        sd_ref_q <= sd_in;
    end

    // Move the reference-domain detect into the bit clock domain.
    always_ff @(posedge bit_clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], sd_ref_q};
    end

    // Select the source and apply gating.
    always_comb begin
        sd_out  = sd_ref_q;
        sd_sync = sync_q[SYNC_STAGES-1];
        gate    = loop_n & ~sd_sync;
        if (gate) begin
            ser_bit = 1'b0;
        end else begin
            ser_bit = loop_n ? line_sin : loop_sin;
        end
    end
endmodule

// File: rtl/nsr_nrzi_dec.sv
`timescale 1ns/1ps
// Module: NRZI to NRZ decoder.
// Outputs 1 when the current serial bit differs from the previous one.
// Assumes: the previous-bit state resets to 0.
module nsr_nrzi_dec (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic ser_bit,
    output logic nrz_bit
);
    logic prev_q;

    // Remember the last sampled serial bit.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ser_bit;
    end

    // A transition decodes as a one.
    always_comb begin
        nrz_bit = ser_bit ^ prev_q;
    end
endmodule

// File: rtl/nsr_sym_div.sv
`timescale 1ns/1ps
// Module: divide-by-SYM_BITS symbol clock generator.
// sym_clk is registered and high for HIGH_BITS bit times, starting at reset.
// load marks the bit-clock edge on which sym_clk falls.
// Assumes: 0 < HIGH_BITS < SYM_BITS.
module nsr_sym_div #(
    parameter int unsigned SYM_BITS  = 5,
    parameter int unsigned HIGH_BITS = 2
) (
    input  logic bit_clk,
    input  logic rst_n,
    output logic sym_clk,
    output logic load
);
    localparam int unsigned CW = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;
    localparam logic [CW-1:0] LAST  = CW'(SYM_BITS - 1);
    localparam logic [CW-1:0] HIGHC = CW'(HIGH_BITS);
    localparam logic [CW-1:0] FALLC = CW'(HIGH_BITS - 1);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          sym_q;

    // Next bit position within the symbol.
    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        load    = (cnt_q == FALLC);
        sym_clk = sym_q;
    end

    // Advance the position and register the clock shape.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sym_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            sym_q <= (cnt_nxt < HIGHC);
        end
    end
endmodule

// File: rtl/nsr_deser.sv
`timescale 1ns/1ps
// Module: serial-in shifter and parallel output register.
// The first bit of each group ends up in the MSB of sym_data.
// Assumes: load is asserted on the edge where the symbol clock falls.
module nsr_deser #(
    parameter int unsigned SYM_BITS = 5
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic                nrz_bit,
    input  logic                load,
    input  logic                gate,
    output logic [SYM_BITS-1:0] sym_data
);
    logic [SYM_BITS-2:0] shift_q;
    logic [SYM_BITS-1:0] out_q;
    logic [SYM_BITS-1:0] group;

    // Completed group including the bit arriving now.
    always_comb begin
        group    = {shift_q, nrz_bit};
        sym_data = out_q;
    end

    // Shift NRZ bits in, one per bit clock.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= group[SYM_BITS-2:0];
    end

    // Update the parallel register at the symbol boundary or force zero.
    always_ff @(posedge bit_clk) begin
        if (!rst_n || gate) out_q <= '0;
        else if (load)      out_q <= group;
    end
endmodule

// File: rtl/nrzi_symbol_rx.sv
`timescale 1ns/1ps
// Module: NRZI serial symbol receiver top.
// Chains source select, NRZI decoder, divider and deserialiser.
// Assumes: bit_clk is the recovered bit clock; ref_clk is asynchronous to it.
module nrzi_symbol_rx
    import nsr_pkg::*;
#(
    parameter int unsigned SYM_BITS    = SYM_BITS_DEF,
    parameter int unsigned HIGH_BITS   = HIGH_BITS_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic                bit_clk,
    input  logic                ref_clk,
    input  logic                rst_n,
    input  logic                loop_n,
    input  logic                line_sin,
    input  logic                loop_sin,
    input  logic                sd_in,
    output logic                sym_clk,
    output logic [SYM_BITS-1:0] sym_data,
    output logic                sd_out
);
    logic sd_sync;
    logic gate;
    logic ser_bit;
    logic nrz_bit;
    logic load;

    nsr_line_select #(.SYNC_STAGES(SYNC_STAGES)) sel_i (
        .bit_clk (bit_clk),
        .ref_clk (ref_clk),
        .loop_n  (loop_n),
        .line_sin(line_sin),
        .loop_sin(loop_sin),
        .sd_in   (sd_in),
        .sd_out  (sd_out),
        .sd_sync (sd_sync),
        .gate    (gate),
        .ser_bit (ser_bit)
    );

    nsr_nrzi_dec dec_i (
        .bit_clk(bit_clk),
        .rst_n  (rst_n),
        .ser_bit(ser_bit),
        .nrz_bit(nrz_bit)
    );

    nsr_sym_div #(.SYM_BITS(SYM_BITS), .HIGH_BITS(HIGH_BITS)) div_i (
        .bit_clk(bit_clk),
        .rst_n  (rst_n),
        .sym_clk(sym_clk),
        .load   (load)
    );

    nsr_deser #(.SYM_BITS(SYM_BITS)) des_i (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .nrz_bit (nrz_bit),
        .load    (load),
        .gate    (gate),
        .sym_data(sym_data)
    );
endmodule

// File: rtl/nrzi_symbol_rx_chk.sv
`timescale 1ns/1ps
// Module: property checker for nrzi_symbol_rx, attached by bind.
// Assumes the default 2-high / 3-low symbol clock shape.
module nrzi_symbol_rx_chk #(
    parameter int unsigned SYM_BITS = 5
) (
    input logic                bit_clk,
    input logic                ref_clk,
    input logic                rst_n,
    input logic                loop_n,
    input logic                sd_in,
    input logic                sd_sync,
    input logic                sym_clk,
    input logic [SYM_BITS-1:0] sym_data,
    input logic                sd_out
);
    AST_SYM_HIGH_TWO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sym_clk) |=> sym_clk);                                   // R5
    AST_SYM_HIGH_END: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sym_clk) |-> ##2 !sym_clk);                              // R5
    AST_SYM_LOW_THREE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(sym_clk) |-> ##2 !sym_clk);                              // R5
    AST_SYM_LOW_END: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(sym_clk) |-> ##3 sym_clk);                               // R5
    AST_DATA_ON_FALL: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$stable(sym_data) |-> ($fell(sym_clk) || sym_data == '0));    // R6
    AST_GATE_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (loop_n && !sd_sync) |=> (sym_data == '0));                    // R3
    AST_RESET_STATE: assert property (@(posedge bit_clk)
        !rst_n |=> (sym_data == '0 && sym_clk));                       // R9
    AST_SD_FOLLOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sd_out == $past(sd_in));                                       // R8
endmodule

bind nrzi_symbol_rx nrzi_symbol_rx_chk #(.SYM_BITS(SYM_BITS)) chk_i (
    .bit_clk (bit_clk),
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .loop_n  (loop_n),
    .sd_in   (sd_in),
    .sd_sync (sd_sync),
    .sym_clk (sym_clk),
    .sym_data(sym_data),
    .sd_out  (sd_out)
);

// File: tb/nrzi_symbol_rx_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every symbol value through both paths, random streams,
// signal-detect gating and reset, using a bit-level reference model.
module nrzi_symbol_rx_tb_top;
    logic       bit_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       loop_n  = 1'b1;
    logic       line_sin = 1'b0;
    logic       loop_sin = 1'b0;
    logic       sd_in   = 1'b1;
    logic       sym_clk;
    logic [4:0] sym_data;
    logic       sd_out;

    int         checks = 0;
    int         errors = 0;
    int         k = 0;
    logic       prev_b = 1'b0;
    logic [4:0] exp_sh = '0;
    logic [4:0] last_q = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit         chk_en = 1'b1;
    bit         done = 1'b0;
    string      cur_tag = "R7";

    nrzi_symbol_rx dut_i (
        .bit_clk (bit_clk),
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .loop_n  (loop_n),
        .line_sin(line_sin),
        .loop_sin(loop_sin),
        .sd_in   (sd_in),
        .sym_clk (sym_clk),
        .sym_data(sym_data),
        .sd_out  (sd_out)
    );

    always #4  bit_clk = ~bit_clk;   // 125 MHz
    always #20 ref_clk = ~ref_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_rand(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    // R9: apply reset, check reset state, release and restart the model.
    task automatic do_reset();
        @(negedge bit_clk) rst_n = 1'b0;
        repeat (4) @(posedge bit_clk);
        #2;
        chk(sym_data == 5'd0, "R9 data in reset", int'(sym_data), 0);
        chk(sym_clk == 1'b1, "R9 sym_clk in reset", int'(sym_clk), 1);
        @(negedge bit_clk) rst_n = 1'b1;
        k = 0; prev_b = 1'b0; exp_sh = '0; last_q = '0;
    endtask

    // Drive one serial bit, advance the model, check outputs after the edge.
    task automatic step(input logic b);
        logic n;
        logic nrz;
        logic exp_sym;
        int   ph;
        next_rand(n);
        if (loop_n) begin line_sin = b; loop_sin = n; end
        else        begin loop_sin = b; line_sin = n; end
        @(posedge bit_clk);
        #2;
        nrz    = b ^ prev_b;                 // R4
        prev_b = b;
        exp_sh = {exp_sh[3:0], nrz};         // R7 earliest bit ends in bit 4
        ph     = k % 5;
        exp_sym = (((k + 1) % 5) < 2);       // R5
        chk(sym_clk == exp_sym, "R5 sym_clk shape", int'(sym_clk), int'(exp_sym));
        if (chk_en) begin
            if (ph == 1) begin
                chk(sym_data == exp_sh, cur_tag, int'(sym_data), int'(exp_sh));
                last_q = exp_sh;
            end else begin
                chk(sym_data == last_q, "R6 hold between falls", int'(sym_data), int'(last_q));
            end
        end
        k++;
    endtask

    task automatic step_nrz(input logic v);
        step(prev_b ^ v);
    endtask

    task automatic sweep_symbols(input bit reverse);
        step_nrz(1'b0);
        step_nrz(1'b0);
        for (int s = 0; s < 32; s++) begin
            logic [4:0] v;
            v = reverse ? 5'(31 - s) : 5'(s);
            for (int i = 4; i >= 0; i--) step_nrz(v[i]);
        end
    endtask

    initial begin
        logic r;
        logic prev_sd;
        repeat (15) @(posedge bit_clk);
        // R8: signal detect follows sd_in on ref_clk.
        prev_sd = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic v;
            v = (i % 2 == 0) ? 1'b0 : 1'b1;
            @(negedge ref_clk) sd_in = v;
            #1;
            chk(sd_out == prev_sd, "R8 sd_out before edge", int'(sd_out), int'(prev_sd));
            @(posedge ref_clk);
            #2;
            chk(sd_out == v, "R8 sd_out after edge", int'(sd_out), int'(v));
            prev_sd = v;
        end
        sd_in = 1'b1;
        repeat (30) @(posedge bit_clk);

        // Line path, every symbol value.
        loop_n = 1'b1;
        do_reset();
        cur_tag = "R1 R4 R7 line symbol";
        sweep_symbols(1'b0);
        cur_tag = "R1 R4 R7 line random";
        for (int i = 0; i < 200; i++) begin next_rand(r); step(r); end

        // R4: first bit of 1 right after reset decodes as a one.
        do_reset();
        cur_tag = "R4 first bit after reset";
        step(1'b1); step(1'b1); step(1'b0); step(1'b0); step(1'b1);
        step(1'b0); step(1'b1);

        // Loopback path with signal detect low, then toggling.
        @(negedge bit_clk) loop_n = 1'b0;
        sd_in = 1'b0;
        repeat (30) @(posedge bit_clk);
        do_reset();
        cur_tag = "R1 R2 loopback symbol sd low";
        sweep_symbols(1'b1);
        cur_tag = "R2 loopback sd toggling";
        for (int i = 0; i < 200; i++) begin
            if (i % 7 == 0) sd_in = ~sd_in;
            next_rand(r); step(r);
        end

        // R3: gating in line mode.
        loop_n = 1'b1;
        sd_in  = 1'b1;
        repeat (30) @(posedge bit_clk);
        do_reset();
        cur_tag = "R7 before gating";
        for (int i = 0; i < 20; i++) begin next_rand(r); step(r); end
        sd_in  = 1'b0;
        chk_en = 1'b0;
        for (int i = 0; i < 30; i++) begin next_rand(r); step(r); end
        for (int i = 0; i < 15; i++) begin
            next_rand(r); step(r);
            chk(sym_data == 5'd0, "R3 gated output zero", int'(sym_data), 0);
        end
        chk_en = 1'b1;
        sd_in  = 1'b1;
        repeat (30) @(posedge bit_clk);

        // R9: reset in the middle of a symbol restarts the divider.
        do_reset();
        cur_tag = "R9 R7 after mid-symbol reset";
        step(1'b1); step(1'b0); step(1'b1);
        do_reset();
        for (int i = 0; i < 40; i++) begin next_rand(r); step(r); end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule